// File: doc/BRIEF.md
# CAN Adapter Interrupt and Address Decode Glue

This block is the glue logic of a CAN adapter card that plugs into a host bus. It sits between a simple host register bus and a single CAN controller core. The host bus has three region selects. The bridge region holds a 32-bit interrupt control and status word. The controller window passes byte accesses through to the controller's byte-wide register port. The version region returns a fixed identification byte. When the add-on enable bit is set, the block gates the controller's level interrupt onto the host interrupt line.

Every host read is answered one clock after the request, with a valid strobe. Forwarded controller reads complete in that same clock. Reading the control word always reports the live controller interrupt in the pending bit, whatever value was last stored there. A card reset clears the control word and is also passed to the controller as a hardware reset.

Top module: `can_card_glue`

## Requirements
- R1: While rst_n is low at a clock edge, the control word clears to zero. After that edge host_irq and host_rvalid are low, so a read of the control word after reset returns only the live pending bit.
- R2: host_irq is a register. After each clock edge it equals the enable bit (bit 13 of the control word, as held after that edge) ANDed with the ctl_irq level sampled at that edge. A change on ctl_irq therefore reaches host_irq one clock later.
- R3: A 32-bit write to bridge offset 0x38 stores the whole word. If ctl_irq is high and bit 13 of the written word changes the enable, host_irq takes the new enable value after that same edge.
- R4: A 32-bit read of bridge offset 0x38 returns the stored word, except that bit 23 carries the ctl_irq level sampled in the request cycle. This holds whether the enable is set or clear.
- R5: Bridge accesses at any offset other than 0x38 read zero and have no effect when written. Bridge accesses with host_wide low are also ignored and read zero.
- R6: A controller window access below offset 0x20 raises ctl_req in the same cycle, with ctl_wr, ctl_addr (the low 5 offset bits) and ctl_wdata (host_wdata bits 7:0). A read returns ctl_rdata zero-extended to 32 bits.
- R7: A controller window access at offset 0x20 or above does not raise ctl_req, and a read there returns zero.
- R8: A read of version offset 7 returns 0xD0, which is version 13 in bits 7:4 and zero in bits 3:0. Other version offsets read zero. Writes to the version region change nothing.
- R9: host_rvalid is high for exactly the one cycle after each read request, in every region and at every offset. It stays low after writes and after idle cycles.
- R10: ctl_hw_reset is high while rst_n is low and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low card reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 32-bit access (required by the bridge region) |
| sel_bridge | input | 1 | Bridge control region select (highest priority) |
| sel_ctl | input | 1 | Controller window select |
| sel_ver | input | 1 | Version region select (lowest priority) |
| host_addr | input | 7 | Byte offset inside the selected region |
| host_wdata | input | 32 | Write data; byte regions use bits 7:0 |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response strobe, one cycle after a read request |
| host_irq | output | 1 | Registered host interrupt line |
| ctl_irq | input | 1 | Controller level interrupt |
| ctl_req | output | 1 | Controller port access strobe |
| ctl_wr | output | 1 | Controller port write flag |
| ctl_addr | output | 5 | Controller register offset |
| ctl_wdata | output | 8 | Controller write byte |
| ctl_rdata | input | 8 | Controller read byte, valid in the request cycle |
| ctl_hw_reset | output | 1 | Hardware reset to the controller |

## Verification
The interrupt gate is exercised with all four combinations of the enable and the controller level. It is also tried with the enable flipped by a write while the interrupt is pending, which separates an immediate response on the write edge from one that waits for the next level change. The control word is read back with the pending bit written one way and the live level the other way, which shows that bit 23 is taken live and not from storage. Window accesses at 0x1F against 0x20, version offset 7 against a neighbour, and narrow against wide bridge accesses locate each decode boundary exactly.

// File: rtl/can_glue_pkg.sv
// Package: shared region type and the decode helper for the CAN adapter glue.
// Assumes at most one region select is meaningful per access; priority
// resolves overlaps (bridge, then controller window, then version).
package can_glue_pkg;

    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_BRIDGE = 2'd1,
        RGN_CTL    = 2'd2,
        RGN_VER    = 2'd3
    } region_e;

    // Pick the addressed region from the three selects by fixed priority.
    function automatic region_e pick_region(input logic s_bridge,
                                            input logic s_ctl,
                                            input logic s_ver);
        if (s_bridge)   return RGN_BRIDGE;
        else if (s_ctl) return RGN_CTL;
        else if (s_ver) return RGN_VER;
        else            return RGN_NONE;
    endfunction

endpackage

// File: rtl/can_glue_csr.sv
// Module: interrupt control/status word and the host interrupt gate.
// Holds the 32-bit control word and registers the gated host interrupt.
// Assumes wr_hit is already qualified (bridge region, wide, CSR offset).
module can_glue_csr #(
    parameter int DW       = 32,
    parameter int EN_BIT   = 13,
    parameter int PEND_BIT = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    input  logic          ctl_irq,
    output logic [DW-1:0] csr_q,
    output logic [DW-1:0] rd_word,
    output logic          host_irq
);

    logic en_next;

    // Enable value that will hold after this edge (written or kept).
    always_comb begin
        en_next = wr_hit ? wdata[EN_BIT] : csr_q[EN_BIT];
    end

    // Stored word, with the pending bit replaced by the live level on reads.
    always_comb begin
        rd_word           = csr_q;
        rd_word[PEND_BIT] = ctl_irq;
    end

    // Control word storage: cleared by reset, replaced whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)      csr_q <= '0;
        else if (wr_hit) csr_q <= wdata;
    end

    // Registered interrupt gate: follows the level only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) host_irq <= 1'b0;
        else        host_irq <= en_next & ctl_irq;
    end

endmodule

// File: rtl/can_glue_ctlwin.sv
// Module: controller window forwarder.
// Passes byte accesses below CTL_SPAN straight to the controller port in the
// request cycle. Assumes the controller returns read data combinationally.
module can_glue_ctlwin #(
    parameter int AW       = 7,
    parameter int CTL_SPAN = 32,
    parameter int CTL_DW   = 8,
    localparam int CTL_AW  = $clog2(CTL_SPAN)
) (
    input  logic              hit,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [CTL_DW-1:0] wdata,
    output logic              in_range,
    output logic              ctl_req,
    output logic              ctl_wr,
    output logic [CTL_AW-1:0] ctl_addr,
    output logic [CTL_DW-1:0] ctl_wdata
);

    // Range test and port drive for the controller window.
    always_comb begin
        in_range  = (addr < AW'(CTL_SPAN));
        ctl_req   = hit & in_range;
        ctl_wr    = wr;
        ctl_addr  = addr[CTL_AW-1:0];
        ctl_wdata = wdata;
    end

endmodule

// File: rtl/can_glue_verreg.sv
// Module: fixed version register.
// Returns the version number in the high nibble at one offset, zero elsewhere.
// Stateless: writes have no target.
module can_glue_verreg #(
    parameter int          AW      = 7,
    parameter int          VER_OFS = 7,
    parameter logic [3:0]  VER_NUM = 4'd13
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    rd_byte
);

    localparam logic [7:0] VER_BYTE = {VER_NUM, 4'h0};

    // Offset match for the version byte.
    always_comb begin
        rd_byte = (addr == AW'(VER_OFS)) ? VER_BYTE : 8'h00;
    end

endmodule

// File: rtl/can_card_glue.sv
// Module: top of the CAN adapter glue.
// Decodes the three host regions, owns the registered read response and
// drives the controller reset. Assumes single-cycle host requests.
module can_card_glue
    import can_glue_pkg::*;
#(
    parameter int          AW       = 7,
    parameter int          DW       = 32,
    parameter int          CTL_DW   = 8,
    parameter int          CTL_SPAN = 32,
    parameter logic [6:0]  CSR_OFS  = 7'h38,
    parameter int          EN_BIT   = 13,
    parameter int          PEND_BIT = 23,
    parameter int          VER_OFS  = 7,
    parameter logic [3:0]  VER_NUM  = 4'd13,
    localparam int         CTL_AW   = $clog2(CTL_SPAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic              host_wide,
    input  logic              sel_bridge,
    input  logic              sel_ctl,
    input  logic              sel_ver,
    input  logic [AW-1:0]     host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_rvalid,
    output logic              host_irq,
    input  logic              ctl_irq,
    output logic              ctl_req,
    output logic              ctl_wr,
    output logic [CTL_AW-1:0] ctl_addr,
    output logic [CTL_DW-1:0] ctl_wdata,
    input  logic [CTL_DW-1:0] ctl_rdata,
    output logic              ctl_hw_reset
);

    region_e         rgn;
    logic            csr_hit;
    logic            csr_wr_hit;
    logic            ctl_hit;
    logic            ctl_in_range;
    logic [DW-1:0]   csr_q;
    logic [DW-1:0]   csr_rd;
    logic [7:0]      ver_byte;
    logic [DW-1:0]   rd_next;

    // Region decode and control word hit qualification.
    always_comb begin
        rgn        = pick_region(sel_bridge, sel_ctl, sel_ver);
        csr_hit    = host_req && (rgn == RGN_BRIDGE) && host_wide
                     && (host_addr == CSR_OFS);
        csr_wr_hit = csr_hit && host_wr;
        ctl_hit    = host_req && (rgn == RGN_CTL);
    end

    can_glue_csr #(
        .DW       (DW),
        .EN_BIT   (EN_BIT),
        .PEND_BIT (PEND_BIT)
    ) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (csr_wr_hit),
        .wdata    (host_wdata),
        .ctl_irq  (ctl_irq),
        .csr_q    (csr_q),
        .rd_word  (csr_rd),
        .host_irq (host_irq)
    );

    can_glue_ctlwin #(
        .AW       (AW),
        .CTL_SPAN (CTL_SPAN),
        .CTL_DW   (CTL_DW)
    ) u_ctlwin (
        .hit       (ctl_hit),
        .wr        (host_wr),
        .addr      (host_addr),
        .wdata     (host_wdata[CTL_DW-1:0]),
        .in_range  (ctl_in_range),
        .ctl_req   (ctl_req),
        .ctl_wr    (ctl_wr),
        .ctl_addr  (ctl_addr),
        .ctl_wdata (ctl_wdata)
    );

    can_glue_verreg #(
        .AW      (AW),
        .VER_OFS (VER_OFS),
        .VER_NUM (VER_NUM)
    ) u_ver (
        .addr    (host_addr),
        .rd_byte (ver_byte)
    );

    // Read data selection for the addressed region.
    always_comb begin
        rd_next = '0;
        unique case (rgn)
            RGN_BRIDGE: if (csr_hit)      rd_next = csr_rd;
            RGN_CTL:    if (ctl_in_range) rd_next = DW'(ctl_rdata);
            RGN_VER:    rd_next = DW'(ver_byte);
            default:    rd_next = '0;
        endcase
    end

    // Registered read response, one clock after each read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= host_req && !host_wr;
            if (host_req && !host_wr) host_rdata <= rd_next;
        end
    end

    // Card reset forwarded to the controller as a hardware reset.
    always_comb begin
        ctl_hw_reset = !rst_n;
    end

endmodule

// File: rtl/can_glue_chk.sv
// Module: assertion checker for can_card_glue, attached by bind below.
// Observes ports and the stored control word only; drives nothing.
module can_glue_chk #(
    parameter int          AW       = 7,
    parameter int          DW       = 32,
    parameter int          CTL_SPAN = 32,
    parameter logic [6:0]  CSR_OFS  = 7'h38,
    parameter int          EN_BIT   = 13,
    parameter int          PEND_BIT = 23,
    parameter int          VER_OFS  = 7,
    parameter logic [3:0]  VER_NUM  = 4'd13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_req,
    input logic          host_wr,
    input logic          host_wide,
    input logic          sel_bridge,
    input logic          sel_ctl,
    input logic          sel_ver,
    input logic [AW-1:0] host_addr,
    input logic [DW-1:0] host_wdata,
    input logic [DW-1:0] host_rdata,
    input logic          host_rvalid,
    input logic          host_irq,
    input logic          ctl_irq,
    input logic          ctl_req,
    input logic          ctl_hw_reset,
    input logic [DW-1:0] csr_q
);

    logic csr_acc;
    logic ctl_acc;
    logic ver_acc;

    // Access classification from the host ports.
    always_comb begin
        csr_acc = host_req && sel_bridge && host_wide && (host_addr == CSR_OFS);
        ctl_acc = host_req && !sel_bridge && sel_ctl;
        ver_acc = host_req && !sel_bridge && !sel_ctl && sel_ver;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!host_irq && !host_rvalid));

    p_irq_low_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_irq |=> !host_irq);

    p_irq_gated_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_q[EN_BIT] && !(csr_acc && host_wr)) |=> !host_irq);

    p_enable_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_acc && host_wr && host_wdata[EN_BIT] && ctl_irq) |=> host_irq);

    p_status_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_acc && !host_wr) |=> (host_rdata[PEND_BIT] == $past(ctl_irq)));

    p_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_acc && (host_addr < AW'(CTL_SPAN))) |-> ctl_req);

    p_window_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_acc && (host_addr >= AW'(CTL_SPAN))) |-> !ctl_req);

    p_version_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ver_acc && !host_wr && (host_addr == AW'(VER_OFS)))
        |=> (host_rdata == DW'({VER_NUM, 4'h0})));

    p_rvalid_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_wr) |=> host_rvalid);

    p_rvalid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && !host_wr) |=> !host_rvalid);

    // R10: controller reset tracks the card reset.
    always @(posedge clk) begin
        p_ctl_reset_r10: assert (ctl_hw_reset == !rst_n);
    end

endmodule

bind can_card_glue can_glue_chk #(
    .AW       (AW),
    .DW       (DW),
    .CTL_SPAN (CTL_SPAN),
    .CSR_OFS  (CSR_OFS),
    .EN_BIT   (EN_BIT),
    .PEND_BIT (PEND_BIT),
    .VER_OFS  (VER_OFS),
    .VER_NUM  (VER_NUM)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .host_wr      (host_wr),
    .host_wide    (host_wide),
    .sel_bridge   (sel_bridge),
    .sel_ctl      (sel_ctl),
    .sel_ver      (sel_ver),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .host_rvalid  (host_rvalid),
    .host_irq     (host_irq),
    .ctl_irq      (ctl_irq),
    .ctl_req      (ctl_req),
    .ctl_hw_reset (ctl_hw_reset),
    .csr_q        (csr_q)
);

// File: tb/tb_can_card_glue.sv
`timescale 1ns/1ps
// Bench for can_card_glue: a vector table walked by one loop, then directed
// tests for the controller write path, irq latency and mid-run reset.
module tb_can_card_glue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_wide = 1'b0;
    logic        sel_bridge = 1'b0;
    logic        sel_ctl = 1'b0;
    logic        sel_ver = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        host_irq;
    logic        ctl_irq = 1'b0;
    logic        ctl_req;
    logic        ctl_wr;
    logic [4:0]  ctl_addr;
    logic [7:0]  ctl_wdata;
    logic [7:0]  ctl_rdata;
    logic        ctl_hw_reset;

    int n_checks = 0;
    int n_fails  = 0;
    int ctl_wr_cnt = 0;
    logic [4:0] ctl_last_addr = '0;
    logic [7:0] ctl_last_data = '0;

    always #2 clk = ~clk;

    can_card_glue dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_wide(host_wide), .sel_bridge(sel_bridge), .sel_ctl(sel_ctl),
        .sel_ver(sel_ver), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_irq(host_irq),
        .ctl_irq(ctl_irq), .ctl_req(ctl_req), .ctl_wr(ctl_wr),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .ctl_hw_reset(ctl_hw_reset)
    );

    // Controller model: read byte is a pattern of the offset; writes logged.
    assign ctl_rdata = 8'h5A ^ {3'b000, ctl_addr};
    always @(posedge clk) begin
        if (ctl_req && ctl_wr) begin
            ctl_wr_cnt    <= ctl_wr_cnt + 1;
            ctl_last_addr <= ctl_addr;
            ctl_last_data <= ctl_wdata;
        end
    end

    typedef struct packed {
        logic [2:0]  sel;     // {ver, ctl, bridge}
        logic        wide;
        logic        wr;
        logic [6:0]  addr;
        logic [31:0] wdata;
        logic        irq;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [0:NV-1] = '{
        '{3'b001, 1'b1, 1'b0, 7'h38, 32'h0,        1'b0, 32'h0,        1'b0, 4'd1}, // R1 reset word
        '{3'b001, 1'b1, 1'b0, 7'h38, 32'h0,        1'b1, 32'h00800000, 1'b0, 4'd4}, // R4 pending, enable clear
        '{3'b001, 1'b1, 1'b1, 7'h38, 32'h00002005, 1'b1, 32'h0,        1'b1, 4'd3}, // R3 enable on while pending
        '{3'b001, 1'b1, 1'b0, 7'h38, 32'h0,        1'b1, 32'h00802005, 1'b1, 4'd4}, // R4 enable set
        '{3'b001, 1'b1, 1'b1, 7'h38, 32'h00802005, 1'b0, 32'h0,        1'b0, 4'd2}, // R2 level low
        '{3'b001, 1'b1, 1'b0, 7'h38, 32'h0,        1'b0, 32'h00002005, 1'b0, 4'd4}, // R4 stored bit23 hidden
        '{3'b001, 1'b1, 1'b0, 7'h38, 32'h0,        1'b1, 32'h00802005, 1'b1, 4'd2}, // R2 level high
        '{3'b001, 1'b1, 1'b1, 7'h38, 32'h00000005, 1'b1, 32'h0,        1'b0, 4'd3}, // R3 enable off while pending
        '{3'b001, 1'b1, 1'b0, 7'h38, 32'h0,        1'b1, 32'h00800005, 1'b0, 4'd4}, // R4 whole word stored
        '{3'b001, 1'b1, 1'b1, 7'h3C, 32'hFFFFFFFF, 1'b1, 32'h0,        1'b0, 4'd5}, // R5 other offset write
        '{3'b001, 1'b1, 1'b0, 7'h3C, 32'h0,        1'b1, 32'h0,        1'b0, 4'd5}, // R5 other offset read
        '{3'b001, 1'b0, 1'b1, 7'h38, 32'h00002000, 1'b1, 32'h0,        1'b0, 4'd5}, // R5 narrow write dropped
        '{3'b001, 1'b1, 1'b0, 7'h38, 32'h0,        1'b1, 32'h00800005, 1'b0, 4'd5}, // R5 word unchanged
        '{3'b001, 1'b0, 1'b0, 7'h38, 32'h0,        1'b1, 32'h0,        1'b0, 4'd5}, // R5 narrow read zero
        '{3'b100, 1'b0, 1'b0, 7'h07, 32'h0,        1'b0, 32'h000000D0, 1'b0, 4'd8}, // R8 version
        '{3'b100, 1'b0, 1'b0, 7'h03, 32'h0,        1'b0, 32'h0,        1'b0, 4'd8}, // R8 other offset
        '{3'b100, 1'b0, 1'b1, 7'h07, 32'h000000FF, 1'b0, 32'h0,        1'b0, 4'd8}, // R8 write ignored
        '{3'b100, 1'b0, 1'b0, 7'h07, 32'h0,        1'b0, 32'h000000D0, 1'b0, 4'd8}, // R8 still 0xD0
        '{3'b010, 1'b0, 1'b0, 7'h05, 32'h0,        1'b0, 32'h0000005F, 1'b0, 4'd6}, // R6 forwarded read
        '{3'b010, 1'b0, 1'b0, 7'h1F, 32'h0,        1'b0, 32'h00000045, 1'b0, 4'd6}, // R6 last in range
        '{3'b010, 1'b0, 1'b0, 7'h20, 32'h0,        1'b0, 32'h0,        1'b0, 4'd7}  // R7 first out of range
    };

    // Compare and report one check.
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one access at a falling edge, release it at the next one.
    task automatic access(input logic [2:0] sel, input logic wide, input logic wr,
                          input logic [6:0] addr, input logic [31:0] wd, input logic irq);
        @(negedge clk);
        {sel_ver, sel_ctl, sel_bridge} = sel;
        host_wide = wide; host_wr = wr; host_addr = addr; host_wdata = wd;
        ctl_irq = irq; host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0; {sel_ver, sel_ctl, sel_bridge} = 3'b000;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int wr_before;
        repeat (3) @(negedge clk);
        check("R10 reset held to controller", {31'b0, ctl_hw_reset}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rvalid after reset", {31'b0, host_rvalid}, 32'h0);
        check("R1 irq after reset", {31'b0, host_irq}, 32'h0);
        check("R10 controller reset released", {31'b0, ctl_hw_reset}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].sel, VECS[i].wide, VECS[i].wr, VECS[i].addr,
                   VECS[i].wdata, VECS[i].irq);
            check($sformatf("R9 rvalid vec%0d (R%0d)", i, VECS[i].req),
                  {31'b0, host_rvalid}, {31'b0, !VECS[i].wr});
            if (!VECS[i].wr)
                check($sformatf("R%0d rdata vec%0d", VECS[i].req, i), host_rdata, VECS[i].exp_rd);
            check($sformatf("R%0d irq vec%0d", VECS[i].req, i),
                  {31'b0, host_irq}, {31'b0, VECS[i].exp_irq});
        end

        // R7 read at top of window and write above it leave the controller idle.
        wr_before = ctl_wr_cnt;
        access(3'b010, 1'b0, 1'b0, 7'h7F, 32'h0, 1'b0);
        check("R7 read 0x7F", host_rdata, 32'h0);
        access(3'b010, 1'b0, 1'b1, 7'h40, 32'h000000AA, 1'b0);
        @(negedge clk);
        check("R7 write above window dropped", ctl_wr_cnt, wr_before);

        // R6 forwarded write carries offset and byte.
        access(3'b010, 1'b0, 1'b1, 7'h10, 32'hFFFFFF3C, 1'b0);
        check("R6 write count", ctl_wr_cnt, wr_before + 1);
        check("R6 write offset", {27'b0, ctl_last_addr}, 32'h10);
        check("R6 write byte", {24'b0, ctl_last_data}, 32'h3C);
        check("R9 no rvalid after write", {31'b0, host_rvalid}, 32'h0);

        // R2 one-clock latency with enable set and no write.
        access(3'b001, 1'b1, 1'b1, 7'h38, 32'h00002000, 1'b0);
        @(negedge clk);
        ctl_irq = 1'b1;
        #1;
        check("R2 irq not yet updated", {31'b0, host_irq}, 32'h0);
        @(negedge clk);
        check("R2 irq one clock later", {31'b0, host_irq}, 32'h1);
        ctl_irq = 1'b0;
        @(negedge clk);
        check("R2 irq drops with level", {31'b0, host_irq}, 32'h0);

        // R1 mid-run reset with enable set and interrupt pending.
        ctl_irq = 1'b1;
        @(negedge clk);
        check("R2 irq high before reset", {31'b0, host_irq}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 controller reset mid-run", {31'b0, ctl_hw_reset}, 32'h1);
        check("R1 irq cleared by reset", {31'b0, host_irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq stays low, enable cleared", {31'b0, host_irq}, 32'h0);
        access(3'b001, 1'b1, 1'b0, 7'h38, 32'h0, 1'b1);
        check("R1 word cleared, live pending", host_rdata, 32'h00800000);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule